// File: doc/BRIEF.md
# Windowed Register File with Rotating Window Pointer

This block is the integer register storage for a processor core that keeps procedure frames in hardware. Software always addresses 32 registers with a 5-bit index. A window pointer selects which physical entries stand behind those indices. Eight global registers are shared by every frame. The other 24 visible registers are split into three groups of eight: outputs, locals and inputs.

Frames sit in a ring of windows, so neighbouring frames overlap. When a procedure is entered, a save strobe moves the pointer down one window. The new frame's input group then lands on the same physical entries as the caller's output group, so arguments pass without any copy. A restore strobe moves the pointer back up. One window is held back for the trap handler and is marked in an invalid-window mask. A save or restore that would land on a marked window does not move the pointer; it raises an overflow or underflow trap instead. The handler spills or fills a window in memory, then loads a new pointer and mask through a load strobe.

The block has two combinational read ports and one synchronous write port.

Top module: `win_regfile`

## Requirements
- R1: Visible indices 0 to 7 (index bits [4:3] = 00) select the global registers. A global reads back the same value at every pointer value.
- R2: Locals (indices 16 to 23, bits [4:3] = 10) and outputs (indices 8 to 15, bits [4:3] = 01) belong to the current window only. A local written in one window does not change the same index in another window.
- R3: Inputs (indices 24 to 31, bits [4:3] = 11) are the outputs of window (pointer+1) mod NWIN. After a save, output k of the caller reads back as input k of the callee, and after a restore, input k reads back as output k.
- R4: A save that does not trap sets the pointer to (pointer−1) mod NWIN. A restore that does not trap sets it to (pointer+1) mod NWIN. Both wrap between 0 and NWIN−1. After reset the pointer is 0 and the mask is 8'b0000_0010.
- R5: A save whose target window (pointer−1) has its mask bit set leaves the pointer unchanged. It raises ovf_trap for exactly one cycle, the cycle after the strobe edge.
- R6: A restore whose target window (pointer+1) has its mask bit set leaves the pointer unchanged. It raises unf_trap for exactly one cycle, the cycle after the strobe edge.
- R7: Index 0 always reads as zero on both read ports, and writes to it are dropped.
- R8: The load strobe writes ctl_cwp and ctl_wim at the clock edge. It overrides any save or restore in the same cycle, and that save or restore raises no trap.
- R9: A write in the same cycle as a save or restore goes to the entry selected by the pointer value from before the move.
- R10: When save and restore are both strobed, the save is carried out and the restore is ignored.
- R11: A write takes effect at the clock edge. A read that selects the same entry in the write cycle returns the old contents, and from the next cycle it returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of pointer, mask and traps |
| rd_a_idx | input | 5 | Visible index, read port A |
| rd_a_data | output | DW | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Visible index, read port B |
| rd_b_data | output | DW | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Visible index for the write |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Save strobe: enter a new frame |
| restore_req | input | 1 | Restore strobe: return to the calling frame |
| ctl_load | input | 1 | Load pointer and mask from ctl_cwp and ctl_wim |
| ctl_cwp | input | log2(NWIN) | Pointer value to load |
| ctl_wim | input | NWIN | Mask value to load |
| cwp | output | log2(NWIN) | Current window pointer |
| wim | output | NWIN | Current invalid-window mask |
| ovf_trap | output | 1 | One-cycle pulse: a save was refused |
| unf_trap | output | 1 | One-cycle pulse: a restore was refused |

## Verification
A wrong pointer does not stay hidden. It shows on the cwp port one cycle after the strobe. It also shows on the read ports in that same cycle, because every output, local and input index then resolves to another window's entries. A wrong overlap term in the input mapping shows as stale data on an input index on the first read after a save. A mask bit tested against the wrong neighbour shows as a trap pulse one window early or late in the full walk around the ring. A lost write to index 0, or a missing zero override on it, shows on the very next read of that index.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
   localparam int VIS_W  = 5;
   localparam int GRP_SZ = 8;

   typedef enum logic [1:0] {
      GRP_GLOBAL = 2'd0,
      GRP_OUT    = 2'd1,
      GRP_LOCAL  = 2'd2,
      GRP_IN     = 2'd3
   } grp_e;
endpackage

// File: rtl/wrf_ptr_ctrl.sv
module wrf_ptr_ctrl #(
   parameter int NWIN = 8,
   parameter int RESET_CWP = 0,
   parameter logic [NWIN-1:0] RESET_WIM = 2,
   localparam int CW = $clog2(NWIN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            save_req,
   input  logic            restore_req,
   input  logic            ctl_load,
   input  logic [CW-1:0]   ctl_cwp,
   input  logic [NWIN-1:0] ctl_wim,
   output logic [CW-1:0]   cwp_q,
   output logic [NWIN-1:0] wim_q,
   output logic            ovf_q,
   output logic            unf_q
);
   logic [CW-1:0]   save_tgt, rest_tgt, cwp_d;
   logic [NWIN-1:0] wim_d;
   logic            take_save, take_rest, ovf_d, unf_d;

   always_comb begin
      save_tgt  = cwp_q - CW'(1);
      rest_tgt  = cwp_q + CW'(1);
      take_save = save_req && !ctl_load;
      take_rest = restore_req && !save_req && !ctl_load;
      ovf_d     = take_save && wim_q[save_tgt];
      unf_d     = take_rest && wim_q[rest_tgt];
      cwp_d     = cwp_q;
      wim_d     = wim_q;
      if (ctl_load) begin
         cwp_d = ctl_cwp;
         wim_d = ctl_wim;
      end else if (take_save && !ovf_d) begin
         cwp_d = save_tgt;
      end else if (take_rest && !unf_d) begin
         cwp_d = rest_tgt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp_q <= CW'(RESET_CWP);
         wim_q <= RESET_WIM;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         cwp_q <= cwp_d;
         wim_q <= wim_d;
         ovf_q <= ovf_d;
         unf_q <= unf_d;
      end
   end

   AST_SAVE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && !ctl_load && !wim_q[cwp_q - CW'(1)]) |=> (cwp_q == $past(cwp_q) - CW'(1))); // R4
   AST_REST_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_req && !save_req && !ctl_load && !wim_q[cwp_q + CW'(1)]) |=> (cwp_q == $past(cwp_q) + CW'(1))); // R4
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> (cwp_q == $past(cwp_q) && $past(save_req))); // R5
   AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      unf_q |-> (cwp_q == $past(cwp_q) && $past(restore_req))); // R6
   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_load |=> (cwp_q == $past(ctl_cwp) && wim_q == $past(ctl_wim) && !ovf_q && !unf_q)); // R8
   AST_BOTH_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && restore_req && !ctl_load) |=> !unf_q); // R10
endmodule

// File: rtl/wrf_addr_map.sv
module wrf_addr_map #(
   parameter int NWIN = 8,
   localparam int CW = $clog2(NWIN),
   localparam int NPHYS = wrf_pkg::GRP_SZ * (1 + 2 * NWIN),
   localparam int PW = $clog2(NPHYS)
) (
   input  logic [CW-1:0]               cwp,
   input  logic [wrf_pkg::VIS_W-1:0]   vis_idx,
   output logic [PW-1:0]               phys_idx
);
   import wrf_pkg::*;

   grp_e          grp;
   logic [CW-1:0] win;
   int            off;

   always_comb begin
      grp = grp_e'(vis_idx[4:3]);
      win = (grp == GRP_IN) ? cwp + CW'(1) : cwp;
      off = (grp == GRP_LOCAL) ? GRP_SZ : 0;
      if (grp == GRP_GLOBAL)
         phys_idx = PW'(int'(vis_idx[2:0]));
      else
         phys_idx = PW'(GRP_SZ + int'(win) * 2 * GRP_SZ + off + int'(vis_idx[2:0]));
   end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
   parameter int NENT = 136,
   parameter int DW = 32,
   parameter int NRD = 2,
   parameter bit ZERO_ENT0 = 1'b1,
   localparam int PW = $clog2(NENT)
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [PW-1:0]           wr_addr,
   input  logic [DW-1:0]           wr_data,
   input  logic [NRD-1:0][PW-1:0]  rd_addr,
   output logic [NRD-1:0][DW-1:0]  rd_data
);
   logic [DW-1:0] mem [NENT];
   logic          wr_ok;

   generate
      if (ZERO_ENT0) begin : g_zero
         assign wr_ok = wr_en && (wr_addr != '0);
         for (genvar i = 0; i < NRD; i++) begin : g_rd
            assign rd_data[i] = (rd_addr[i] == '0) ? '0 : mem[rd_addr[i]];
         end
      end else begin : g_plain
         assign wr_ok = wr_en;
         for (genvar i = 0; i < NRD; i++) begin : g_rd
            assign rd_data[i] = mem[rd_addr[i]];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_addr] <= wr_data;
   end
endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
   parameter int NWIN = 8,
   parameter int DW = 32,
   parameter int RESET_CWP = 0,
   parameter logic [NWIN-1:0] RESET_WIM = 2,
   localparam int CW = $clog2(NWIN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [4:0]      rd_a_idx,
   output logic [DW-1:0]   rd_a_data,
   input  logic [4:0]      rd_b_idx,
   output logic [DW-1:0]   rd_b_data,
   input  logic            wr_en,
   input  logic [4:0]      wr_idx,
   input  logic [DW-1:0]   wr_data,
   input  logic            save_req,
   input  logic            restore_req,
   input  logic            ctl_load,
   input  logic [CW-1:0]   ctl_cwp,
   input  logic [NWIN-1:0] ctl_wim,
   output logic [CW-1:0]   cwp,
   output logic [NWIN-1:0] wim,
   output logic            ovf_trap,
   output logic            unf_trap
);
   localparam int NPHYS = wrf_pkg::GRP_SZ * (1 + 2 * NWIN);
   localparam int PW    = $clog2(NPHYS);
   localparam int NPORT = 3;

   generate
      if (NWIN < 2 || (1 << CW) != NWIN) begin : g_bad_nwin
         $error("win_regfile: NWIN must be a power of two and at least 2");
      end
      if (RESET_CWP < 0 || RESET_CWP >= NWIN) begin : g_bad_cwp
         $error("win_regfile: RESET_CWP out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("win_regfile: DW must be positive");
      end
   endgenerate

   logic [NPORT-1:0][4:0]    vis;
   logic [NPORT-1:0][PW-1:0] phys;
   logic [1:0][PW-1:0]       rd_phys;
   logic [1:0][DW-1:0]       rd_word;

   assign vis[0] = rd_a_idx;
   assign vis[1] = rd_b_idx;
   assign vis[2] = wr_idx;

   wrf_ptr_ctrl #(.NWIN(NWIN), .RESET_CWP(RESET_CWP), .RESET_WIM(RESET_WIM)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .save_req(save_req), .restore_req(restore_req),
      .ctl_load(ctl_load), .ctl_cwp(ctl_cwp), .ctl_wim(ctl_wim),
      .cwp_q(cwp), .wim_q(wim), .ovf_q(ovf_trap), .unf_q(unf_trap)
   );

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_map
         wrf_addr_map #(.NWIN(NWIN)) u_map (
            .cwp(cwp), .vis_idx(vis[p]), .phys_idx(phys[p])
         );
      end
   endgenerate

   assign rd_phys[0] = phys[0];
   assign rd_phys[1] = phys[1];

   wrf_storage #(.NENT(NPHYS), .DW(DW), .NRD(2), .ZERO_ENT0(1'b1)) u_mem (
      .clk(clk), .wr_en(wr_en), .wr_addr(phys[2]), .wr_data(wr_data),
      .rd_addr(rd_phys), .rd_data(rd_word)
   );

   assign rd_a_data = rd_word[0];
   assign rd_b_data = rd_word[1];

   AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == 5'd0) |-> (rd_a_data == '0)); // R7
   AST_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_idx == 5'd0) |-> (rd_b_data == '0)); // R7
   AST_WR_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != 5'd0 && !save_req && !restore_req && !ctl_load)
      |=> (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data))); // R11
   AST_GLOBAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_idx[4:3] == 2'b00 && !wr_en && $stable(rd_b_idx) && ctl_load)
      |=> (rd_b_idx != $past(rd_b_idx) || rd_b_data == $past(rd_b_data))); // R1
endmodule

// File: tb/sim_win_regfile.sv
module sim_win_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, ctl_load = 1'b0;
   logic [2:0]  ctl_cwp = '0, cwp;
   logic [7:0]  ctl_wim = '0, wim;
   logic        ovf_trap, unf_trap;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   win_regfile u0 (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .save_req(save_req), .restore_req(restore_req),
      .ctl_load(ctl_load), .ctl_cwp(ctl_cwp), .ctl_wim(ctl_wim),
      .cwp(cwp), .wim(wim), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
   );

   // {save, restore, expected cwp[2:0], expected ovf, expected unf}
   localparam logic [6:0] VEC [16] = '{
      7'b10_111_00, 7'b10_110_00, 7'b10_101_00, 7'b10_100_00,
      7'b10_011_00, 7'b10_010_00, 7'b10_010_10, 7'b01_011_00,
      7'b01_100_00, 7'b01_101_00, 7'b01_110_00, 7'b01_111_00,
      7'b01_000_00, 7'b01_000_01, 7'b11_111_00, 7'b00_111_00
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] idx, input logic [31:0] d);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic load(input logic [2:0] c, input logic [7:0] m);
      ctl_load = 1'b1; ctl_cwp = c; ctl_wim = m;
      tick();
      ctl_load = 1'b0;
   endtask

   task automatic save_op();
      save_req = 1'b1; tick(); save_req = 1'b0;
   endtask

   task automatic restore_op();
      restore_req = 1'b1; tick(); restore_req = 1'b0;
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog all-reqs actual=%0d expected<=5000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state (R4, R5, R6)
      chk("R4 reset cwp", 32'(cwp), 32'd0);
      chk("R4 reset wim", 32'(wim), 32'h02);
      chk("R5 reset ovf", 32'(ovf_trap), 32'd0);
      chk("R6 reset unf", 32'(unf_trap), 32'd0);

      // Pointer walk table: R4 wrap, R5/R6 traps, R10 save priority
      for (int i = 0; i < 16; i++) begin
         save_req = VEC[i][6]; restore_req = VEC[i][5];
         tick();
         save_req = 1'b0; restore_req = 1'b0;
         chk($sformatf("R4/R10 vec%0d cwp", i), 32'(cwp), 32'(VEC[i][4:2]));
         chk($sformatf("R5 vec%0d ovf", i), 32'(ovf_trap), 32'(VEC[i][1]));
         chk($sformatf("R6 vec%0d unf", i), 32'(unf_trap), 32'(VEC[i][0]));
      end
      chk("R5 ovf one cycle", 32'(ovf_trap), 32'd0);

      // R8: load beats a save in the same cycle
      save_req = 1'b1;
      load(3'd0, 8'h02);
      save_req = 1'b0;
      chk("R8 cwp loaded", 32'(cwp), 32'd0);
      chk("R8 wim loaded", 32'(wim), 32'h02);
      chk("R8 no trap", 32'({ovf_trap, unf_trap}), 32'd0);

      // R7: index 0 stays zero
      wr(5'd0, 32'hDEADBEEF);
      rd_a_idx = 5'd0; rd_b_idx = 5'd0; #1;
      chk("R7 port a zero", rd_a_data, 32'd0);
      chk("R7 port b zero", rd_b_data, 32'd0);

      // R11: write visible only after the edge
      wr(5'd5, 32'h11111111);
      wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'h22222222; rd_a_idx = 5'd5;
      #5;
      chk("R11 old during write", rd_a_data, 32'h11111111);
      tick();
      wr_en = 1'b0;
      chk("R11 new after edge", rd_a_data, 32'h22222222);

      // R1: globals independent of pointer
      load(3'd5, 8'h01);
      chk("R1 global at cwp5", rd_a_data, 32'h22222222);

      // R3: caller output k becomes callee input k
      wr(5'd10, 32'hA0A0A0A0);
      save_op();
      chk("R3 cwp after save", 32'(cwp), 32'd4);
      rd_b_idx = 5'd26; #1;
      chk("R3 out2 seen as in2", rd_b_data, 32'hA0A0A0A0);
      wr(5'd27, 32'hB1B1B1B1);
      restore_op();
      rd_b_idx = 5'd11; #1;
      chk("R3 in3 seen as out3", rd_b_data, 32'hB1B1B1B1);

      // R2: locals private per window
      wr(5'd17, 32'h55550005);
      save_op();
      wr(5'd17, 32'h44440004);
      rd_a_idx = 5'd17; #1;
      chk("R2 local win4", rd_a_data, 32'h44440004);
      restore_op();
      chk("R2 local win5 kept", rd_a_data, 32'h55550005);

      // R9: write alongside save uses old pointer
      wr_en = 1'b1; wr_idx = 5'd18; wr_data = 32'h99990009; save_req = 1'b1;
      tick();
      wr_en = 1'b0; save_req = 1'b0;
      chk("R9 moved", 32'(cwp), 32'd4);
      restore_op();
      rd_a_idx = 5'd18; #1;
      chk("R9 write in old window", rd_a_data, 32'h99990009);

      done = 1'b1;
      finish_run();
   end
endmodule